// File: doc/BRIEF.md
# Reloading Countdown Timer Bank with Wide Time Base

The block holds three down-counters and one wide up-counting time base, all reached through a synchronous word-addressed register port. Two down-counters are 16 bits wide and the third is 32 bits wide. Each one stores a reload value and has a control word. Each one drives its own level interrupt, which goes high when the counter passes through zero. A write to that counter's clear register takes the interrupt low again. The counters do not generate their own rates. They advance on tick-enable pulses from outside: a medium-rate tick (about 508 kHz) or a slow tick (about 2 kHz), chosen per counter.

The time base is 40 bits wide and has no interrupt. It advances on a separate fast tick (about 983 kHz) while its enable bit is set. Software reads it as a 32-bit low word followed by a high register. Reading the low word captures the upper byte, so the high read that follows returns a matching 40-bit value.

A typical driver uses one down-counter as a one-shot or periodic event source and the time base as a monotonic clock. To arm a new count, software clears the enable, writes the reload value, then sets the enable again.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every reload value, count, control word, time-base count, time-base enable and captured byte is zero. All interrupt outputs are low and `rdata` is zero.
- R2: A write to a down-counter's load register (word offset +0 from the channel base) sets both the reload value and the count at once. The count is read at offset +1 and the reload value at offset +0.
- R3: A down-counter whose control bit 7 is set decreases by one on each selected tick. Control bit 3 set selects `mid_tick`; bit 3 clear selects `slow_tick`. With bit 7 clear the count holds.
- R4: A selected tick that arrives while the count is zero is an underflow, and it sets that channel's interrupt. With control bit 6 set, the count reloads from the reload value, so a reload value N gives N+1 ticks between underflows.
- R5: With control bit 6 clear, an underflow wraps the count to all ones of its own width: 0xFFFF for the 16-bit channels and 0xFFFFFFFF for the 32-bit channel.
- R6: A write of any value to a channel's clear register (offset +3) drops its interrupt on the next edge. If an underflow happens on the same edge, the interrupt stays high.
- R7: When a load write and a selected tick fall on the same edge, the written value becomes the count and no underflow is taken.
- R8: Bit 8 of a write to the time-base high register (word 25) sets its enable. While enabled, the time base gains one per `fast_tick`. `irq[3]` never goes high.
- R9: A read of the time-base low word (word 24) returns count bits 31:0 and captures bits 39:32. A read of word 25 returns that captured byte in bits 7:0 and the enable in bit 8.
- R10: Channel bases are word 0, word 8 and word 32, with the 32-bit counter at word 32. Read data appears one cycle after `rd_en` and holds until the next read. Unmapped words read as zero, and writes to them change nothing.
- R11: A control register reads back only bits 7, 6 and 3. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mid_tick | input | 1 | Medium-rate tick enable for the down-counters |
| slow_tick | input | 1 | Slow tick enable for the down-counters |
| fast_tick | input | 1 | Fast tick enable for the time base |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address (byte offset divided by four) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Level interrupts; bits 2:0 for the down-counters, bit 3 for the time base (always low) |

## Verification
Two collisions are the focus: a clear write landing on the same edge as an underflow, and a load write landing on the same edge as a counting tick. The bench provokes each one by loading a count of zero, or by writing a reload value, and driving the tick pulse in the very cycle of the register write. It then judges the interrupt level and the read-back count against a behavioural model that advances on every clock. Underflow keeps the interrupt set, and the load discards the tick.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

   // number of reloading down-counters
   localparam int NCH = 3;

   // control word bit positions (decoded by the driver)
   localparam int CTRL_EN_BIT  = 7;
   localparam int CTRL_PER_BIT = 6;
   localparam int CTRL_SEL_BIT = 3;

   // enable position inside the time-base high register
   localparam int TB_EN_BIT = 8;

   // word offsets inside a channel window
   localparam int OFS_LOAD  = 0;
   localparam int OFS_VALUE = 1;
   localparam int OFS_CTRL  = 2;
   localparam int OFS_CLEAR = 3;

   // time-base word addresses
   localparam int TB_LO_IDX = 24;
   localparam int TB_HI_IDX = 25;

   typedef struct packed {
      logic en;
      logic periodic;
      logic mid_sel;
   } chan_ctrl_t;

   function automatic int chan_base(input int ch);
      case (ch)
         0:       return 0;
         1:       return 8;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/ttb_down_counter.sv
module ttb_down_counter
   import ttb_pkg::*;
#(
   parameter int W      = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mid_tick,
   input  logic              slow_tick,
   input  logic              load_we,
   input  logic              ctrl_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] load_rd,
   output logic [DATA_W-1:0] value_rd,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic              irq,
   output logic              tick_o,
   output logic              zero_o
);

   localparam logic [W-1:0] ALL_ONES = '1;

   logic [W-1:0] load_r;
   logic [W-1:0] cnt_r;
   chan_ctrl_t   ctrl_r;
   logic         irq_r;
   logic         tick_sel;
   logic         at_zero;
   logic         underflow;
   logic         wdata_unused;

   assign wdata_unused = ^wdata;

   assign tick_sel  = ctrl_r.en & (ctrl_r.mid_sel ? mid_tick : slow_tick);
   assign at_zero   = (cnt_r == '0);
   assign underflow = tick_sel & at_zero & ~load_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_r <= '0;
         cnt_r  <= '0;
         ctrl_r <= '0;
         irq_r  <= 1'b0;
      end else begin
         if (ctrl_we) begin
            ctrl_r.en       <= wdata[CTRL_EN_BIT];
            ctrl_r.periodic <= wdata[CTRL_PER_BIT];
            ctrl_r.mid_sel  <= wdata[CTRL_SEL_BIT];
         end
         if (load_we) begin
            load_r <= wdata[W-1:0];
            cnt_r  <= wdata[W-1:0];
         end else if (tick_sel) begin
            if (at_zero) begin
               cnt_r <= ctrl_r.periodic ? load_r : ALL_ONES;
            end else begin
               cnt_r <= cnt_r - 1'b1;
            end
         end
         if (underflow) begin
            irq_r <= 1'b1;
         end else if (clr_we) begin
            irq_r <= 1'b0;
         end
      end
   end

   generate
      if (W < DATA_W) begin : g_ext
         assign load_rd  = {{(DATA_W-W){1'b0}}, load_r};
         assign value_rd = {{(DATA_W-W){1'b0}}, cnt_r};
      end else begin : g_full
         assign load_rd  = load_r;
         assign value_rd = cnt_r;
      end
   endgenerate

   always_comb begin
      ctrl_rd               = '0;
      ctrl_rd[CTRL_EN_BIT]  = ctrl_r.en;
      ctrl_rd[CTRL_PER_BIT] = ctrl_r.periodic;
      ctrl_rd[CTRL_SEL_BIT] = ctrl_r.mid_sel;
   end

   assign irq    = irq_r;
   assign tick_o = tick_sel;
   assign zero_o = at_zero;

endmodule

// File: rtl/ttb_timebase.sv
module ttb_timebase
   import ttb_pkg::*;
#(
   parameter int TB_W   = 40,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_tick,
   input  logic              hi_we,
   input  logic              lo_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] lo_word,
   output logic [DATA_W-1:0] hi_word,
   output logic [TB_W-1:0]   cnt_o
);

   localparam int HI_W = TB_W - DATA_W;

   logic [TB_W-1:0] cnt_r;
   logic [HI_W-1:0] snap_r;
   logic            en_r;
   logic            wdata_unused;

   assign wdata_unused = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r  <= '0;
         snap_r <= '0;
         en_r   <= 1'b0;
      end else begin
         if (en_r && fast_tick) begin
            cnt_r <= cnt_r + 1'b1;
         end
         if (hi_we) begin
            en_r <= wdata[TB_EN_BIT];
         end
         if (lo_rd) begin
            snap_r <= cnt_r[TB_W-1:DATA_W];
         end
      end
   end

   assign lo_word = cnt_r[DATA_W-1:0];

   always_comb begin
      hi_word            = '0;
      hi_word[HI_W-1:0]  = snap_r;
      hi_word[TB_EN_BIT] = en_r;
   end

   assign cnt_o = cnt_r;

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
   import ttb_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 32,
   parameter int WIDE_CH  = 2,
   parameter int TB_W     = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mid_tick,
   input  logic              slow_tick,
   input  logic              fast_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NCH:0]      irq
);

   localparam logic [ADDR_W-1:0] TB_LO_A = ADDR_W'(TB_LO_IDX);
   localparam logic [ADDR_W-1:0] TB_HI_A = ADDR_W'(TB_HI_IDX);

   // elaboration-time parameter checks
   if (TB_W <= DATA_W || TB_W - DATA_W > TB_EN_BIT) begin : g_bad_tb
      $error("time base width must exceed the data width by 1..%0d bits", TB_EN_BIT);
   end
   if (NARROW_W > DATA_W || WIDE_W > DATA_W || NARROW_W < 1) begin : g_bad_ch
      $error("down-counter widths must lie within the data width");
   end
   if ((1 << ADDR_W) <= chan_base(NCH-1) + OFS_CLEAR) begin : g_bad_addr
      $error("address width too small for the register map");
   end
   if (WIDE_CH < 0 || WIDE_CH >= NCH) begin : g_bad_wide
      $error("wide channel index out of range");
   end

   logic [NCH-1:0]    load_we;
   logic [NCH-1:0]    ctrl_we;
   logic [NCH-1:0]    clr_we;
   logic [NCH-1:0]    chan_tick;
   logic [NCH-1:0]    chan_zero;
   logic [NCH-1:0]    chan_irq;
   logic [DATA_W-1:0] chan_rd [NCH];

   logic [DATA_W-1:0] tb_lo;
   logic [DATA_W-1:0] tb_hi;
   logic [TB_W-1:0]   tb_cnt;
   logic              tb_hi_we;
   logic              tb_lo_rd;

   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] rdata_r;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chan
         localparam int CW = (i == WIDE_CH) ? WIDE_W : NARROW_W;
         localparam logic [ADDR_W-1:0] LOAD_A  = ADDR_W'(chan_base(i) + OFS_LOAD);
         localparam logic [ADDR_W-1:0] VALUE_A = ADDR_W'(chan_base(i) + OFS_VALUE);
         localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(chan_base(i) + OFS_CTRL);
         localparam logic [ADDR_W-1:0] CLR_A   = ADDR_W'(chan_base(i) + OFS_CLEAR);

         logic [DATA_W-1:0] load_rd;
         logic [DATA_W-1:0] value_rd;
         logic [DATA_W-1:0] ctrl_rd;

         assign load_we[i] = wr_en && (addr == LOAD_A);
         assign ctrl_we[i] = wr_en && (addr == CTRL_A);
         assign clr_we[i]  = wr_en && (addr == CLR_A);

         ttb_down_counter #(
            .W      (CW),
            .DATA_W (DATA_W)
         ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .mid_tick  (mid_tick),
            .slow_tick (slow_tick),
            .load_we   (load_we[i]),
            .ctrl_we   (ctrl_we[i]),
            .clr_we    (clr_we[i]),
            .wdata     (wdata),
            .load_rd   (load_rd),
            .value_rd  (value_rd),
            .ctrl_rd   (ctrl_rd),
            .irq       (chan_irq[i]),
            .tick_o    (chan_tick[i]),
            .zero_o    (chan_zero[i])
         );

         always_comb begin
            if (addr == LOAD_A) begin
               chan_rd[i] = load_rd;
            end else if (addr == VALUE_A) begin
               chan_rd[i] = value_rd;
            end else if (addr == CTRL_A) begin
               chan_rd[i] = ctrl_rd;
            end else begin
               chan_rd[i] = '0;
            end
         end
      end
   endgenerate

   assign tb_hi_we = wr_en && (addr == TB_HI_A);
   assign tb_lo_rd = rd_en && (addr == TB_LO_A);

   ttb_timebase #(
      .TB_W   (TB_W),
      .DATA_W (DATA_W)
   ) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_tick (fast_tick),
      .hi_we     (tb_hi_we),
      .lo_rd     (tb_lo_rd),
      .wdata     (wdata),
      .lo_word   (tb_lo),
      .hi_word   (tb_hi),
      .cnt_o     (tb_cnt)
   );

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NCH; i++) begin
         rd_next = rd_next | chan_rd[i];
      end
      if (addr == TB_LO_A) begin
         rd_next = rd_next | tb_lo;
      end
      if (addr == TB_HI_A) begin
         rd_next = rd_next | tb_hi;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_r <= '0;
      end else if (rd_en) begin
         rdata_r <= rd_next;
      end
   end

   assign rdata = rdata_r;
   assign irq   = {1'b0, chan_irq};

endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
   parameter int NCH    = 3,
   parameter int DATA_W = 32,
   parameter int TB_W   = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              fast_tick,
   input logic [DATA_W-1:0] rdata,
   input logic [NCH:0]      irq,
   input logic [NCH-1:0]    chan_tick,
   input logic [NCH-1:0]    chan_zero,
   input logic [NCH-1:0]    load_we,
   input logic [NCH-1:0]    clr_we,
   input logic [TB_W-1:0]   tb_cnt
);

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R4: an underflow not overridden by a load raises the interrupt
      p_underflow_sets_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
         chan_tick[i] && chan_zero[i] && !load_we[i] |=> irq[i]);

      // R4: the interrupt rises only after an underflow
      p_irq_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[i]) |-> $past(chan_tick[i] && chan_zero[i]));

      // R6: a clear without a simultaneous underflow drops the interrupt
      p_clear_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
         clr_we[i] && !(chan_tick[i] && chan_zero[i]) |=> !irq[i]);
   end

   // R8: the time base moves only on a fast tick
   p_tb_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_tick |=> $stable(tb_cnt));

   // R10: read data holds between reads
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

endmodule

bind tick_timer_bank ttb_checker #(
   .NCH    (ttb_pkg::NCH),
   .DATA_W (DATA_W),
   .TB_W   (TB_W)
) u_ttb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .fast_tick (fast_tick),
   .rdata     (rdata),
   .irq       (irq),
   .chan_tick (chan_tick),
   .chan_zero (chan_zero),
   .load_we   (load_we),
   .clr_we    (clr_we),
   .tb_cnt    (tb_cnt)
);

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mid_tick = 1'b0;
   logic        slow_tick = 1'b0;
   logic        fast_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;
   bit live    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tick_timer_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mid_tick  (mid_tick),
      .slow_tick (slow_tick),
      .fast_tick (fast_tick),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .irq       (irq)
   );

   // ---------------- behavioural reference model ----------------
   longint unsigned m_load [3];
   longint unsigned m_cnt  [3];
   bit              m_en   [3];
   bit              m_per  [3];
   bit              m_sel  [3];
   bit              m_irq  [3];
   longint unsigned m_tb;
   bit              m_tben;
   longint unsigned m_snap;
   longint unsigned m_rdata;

   function automatic int base_of(int c);
      return (c == 0) ? 0 : (c == 1) ? 8 : 32;
   endfunction

   function automatic longint unsigned mask_of(int c);
      return (c == 2) ? 64'hFFFF_FFFF : 64'hFFFF;
   endfunction

   function automatic longint unsigned model_read(int a);
      for (int c = 0; c < 3; c++) begin
         if (a == base_of(c))     return m_load[c];
         if (a == base_of(c) + 1) return m_cnt[c];
         if (a == base_of(c) + 2)
            return (longint'(m_en[c]) << 7) | (longint'(m_per[c]) << 6) | (longint'(m_sel[c]) << 3);
         if (a == base_of(c) + 3) return 0;
      end
      if (a == 24) return m_tb & 64'hFFFF_FFFF;
      if (a == 25) return (longint'(m_tben) << 8) | m_snap;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) begin
            m_load[c] = 0; m_cnt[c] = 0; m_en[c] = 0;
            m_per[c] = 0; m_sel[c] = 0; m_irq[c] = 0;
         end
         m_tb = 0; m_tben = 0; m_snap = 0; m_rdata = 0;
      end else begin
         if (rd_en) begin
            m_rdata = model_read(int'(addr));
            if (addr == 6'd24) m_snap = (m_tb >> 32) & 64'hFF;
         end
         for (int c = 0; c < 3; c++) begin
            bit tk, lw, cw, clw, uf;
            tk  = m_en[c] && (m_sel[c] ? mid_tick : slow_tick);
            lw  = wr_en && (int'(addr) == base_of(c));
            cw  = wr_en && (int'(addr) == base_of(c) + 2);
            clw = wr_en && (int'(addr) == base_of(c) + 3);
            uf  = tk && (m_cnt[c] == 0) && !lw;
            if (lw) begin
               m_load[c] = longint'(wdata) & mask_of(c);
               m_cnt[c]  = m_load[c];
            end else if (tk) begin
               if (m_cnt[c] == 0) m_cnt[c] = m_per[c] ? m_load[c] : mask_of(c);
               else               m_cnt[c] = m_cnt[c] - 1;
            end
            if (cw) begin
               m_en[c] = wdata[7]; m_per[c] = wdata[6]; m_sel[c] = wdata[3];
            end
            if (uf)       m_irq[c] = 1;
            else if (clw) m_irq[c] = 0;
         end
         if (m_tben && fast_tick) m_tb = (m_tb + 1) & 64'hFF_FFFF_FFFF;
         if (wr_en && addr == 6'd25) m_tben = wdata[8];
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (live && !done) begin
         logic [3:0]  exp_irq;
         logic [31:0] exp_rd;
         exp_irq = {1'b0, m_irq[2], m_irq[1], m_irq[0]};
         exp_rd  = m_rdata[31:0];
         n_tests++;
         if (irq !== exp_irq) begin
            n_fail++;
            $display("FAIL R4/R6 model irq: actual %h expected %h at %0t", irq, exp_irq, $time);
         end
         n_tests++;
         if (rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL R10 model rdata: actual %h expected %h at %0t", rdata, exp_rd, $time);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      rd_en = 1'b1; addr = a;
      step();
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic pulse_mid(input int n);
      for (int k = 0; k < n; k++) begin
         mid_tick = 1'b1; step(); mid_tick = 1'b0;
      end
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live  = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq after reset", {28'b0, irq}, 32'h0);
      rd(6'd1, v);  chk("R1 channel 0 count", v, 32'h0);
      rd(6'd25, v); chk("R1 time-base high", v, 32'h0);

      // R2 load, R4 periodic underflow after N+1 ticks
      wr(6'd0, 32'd5);
      rd(6'd1, v);  chk("R2 load copies into count", v, 32'd5);
      wr(6'd2, 32'h0000_00C8);
      pulse_mid(5);
      chk("R4 no irq before underflow", {31'b0, irq[0]}, 32'h0);
      rd(6'd1, v);  chk("R3 count after five ticks", v, 32'd0);
      pulse_mid(1);
      chk("R4 irq on underflow", {31'b0, irq[0]}, 32'h1);
      rd(6'd1, v);  chk("R4 periodic reload", v, 32'd5);

      // R6 clear, then clear colliding with underflow
      wr(6'd3, 32'h0);
      chk("R6 clear drops irq", {31'b0, irq[0]}, 32'h0);
      wr(6'd0, 32'd0);
      wr_en = 1'b1; addr = 6'd3; wdata = 32'h1234; mid_tick = 1'b1;
      step();
      wr_en = 1'b0; mid_tick = 1'b0;
      chk("R6 underflow beats clear", {31'b0, irq[0]}, 32'h1);
      wr(6'd3, 32'h0);
      chk("R6 clear after collision", {31'b0, irq[0]}, 32'h0);

      // R11 control readback mask
      wr(6'd2, 32'hFFFF_FFFF);
      rd(6'd2, v);  chk("R11 control readback", v, 32'h0000_00C8);
      wr(6'd2, 32'h0);
      wr(6'd3, 32'h0);

      // R5 free-running wrap on 16-bit channel
      wr(6'd8, 32'd1);
      wr(6'd10, 32'h0000_0088);
      pulse_mid(2);
      rd(6'd9, v);  chk("R5 16-bit wrap", v, 32'h0000_FFFF);
      chk("R4 channel 1 irq", {31'b0, irq[1]}, 32'h1);

      // R3 slow select on 32-bit channel, R5 wide wrap
      wr(6'd32, 32'd0);
      wr(6'd34, 32'h0000_0080);
      pulse_mid(1);
      rd(6'd33, v); chk("R3 mid tick ignored on slow select", v, 32'h0);
      slow_tick = 1'b1; step(); slow_tick = 1'b0;
      rd(6'd33, v); chk("R5 32-bit wrap", v, 32'hFFFF_FFFF);
      chk("R10 wide channel irq bit 2", {31'b0, irq[2]}, 32'h1);

      // R7 load and tick on the same edge
      wr_en = 1'b1; addr = 6'd8; wdata = 32'h10; mid_tick = 1'b1;
      step();
      wr_en = 1'b0; mid_tick = 1'b0;
      rd(6'd9, v);  chk("R7 load wins over tick", v, 32'h10);

      // R3 disabled channel holds
      wr(6'd0, 32'd7);
      pulse_mid(3);
      rd(6'd1, v);  chk("R3 disabled holds", v, 32'd7);

      // R8 / R9 time base
      wr(6'd25, 32'h0000_0100);
      fast_tick = 1'b1; step(); step(); step(); fast_tick = 1'b0;
      rd(6'd24, v); chk("R8 time base counts fast ticks", v, 32'd3);
      rd(6'd25, v); chk("R9 high read with enable", v, 32'h0000_0100);
      chk("R8 no time-base irq", {31'b0, irq[3]}, 32'h0);
      wr(6'd25, 32'h0);
      fast_tick = 1'b1; step(); fast_tick = 1'b0;
      rd(6'd24, v); chk("R8 disabled time base holds", v, 32'd3);

      // R10 unmapped space
      rd(6'd5, v);  chk("R10 unmapped read", v, 32'h0);
      wr(6'd4, 32'hDEAD_BEEF);
      rd(6'd0, v);  chk("R10 unmapped write leaves load 0", v, 32'd7);
      rd(6'd8, v);  chk("R10 unmapped write leaves load 1", v, 32'h10);

      repeat (4) step();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule